// File: doc/BRIEF.md
# Rotating-Pattern Disturb Memory Self-Test

This block is a self-test engine placed in front of a single-port synchronous RAM. When it is idle, the RAM port simply follows the functional request inputs. A pulse on `start` hands the RAM to the engine. It then runs a series of passes. Each pass fills the whole array with one data word, optionally waits a programmed number of idle cycles so the stored data can settle, and then reads every word back and compares it with the pattern just written.

The first pass writes a word that has a single cleared bit in the most significant position. Each later pass rotates that word left by one place. After as many passes as the word has bits, the cleared bit has visited every bit position, so every cell has been driven both from one to zero and from zero to one. The first miscompare ends the test at once: the engine releases the RAM and reports `done` together with `fail`. A clean run reports `done` with `fail` low.

The sequence is driven by one counter. Its low field is the RAM address. The bit above the address field selects write (0) or read (1). The bits above that give the pass number, and the pass number sets how far the pattern is rotated.

Top module: `mbd_disturb_bist`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `fail` are low, and `mem_en`, `mem_we`, `mem_addr` and `mem_wdata` follow `sys_en`, `sys_we`, `sys_addr` and `sys_wdata`.
- R2: Each pass performs one RAM access per cycle. It first writes addresses 0 up to DEPTH-1 in ascending order, then reads addresses 0 up to DEPTH-1 in ascending order. The counter bit just above the address field is 0 for the write half and 1 for the read half.
- R3: Pass 0 writes a word whose most significant bit is 0 and whose other bits are 1. For an 8-bit word this is 8'h7F.
- R4: Each pass uses the previous pattern rotated left by one bit (8'hFE in pass 1, 8'hFD in pass 2). The test runs DATA_W passes in total.
- R5: Between the last write and the first read of every pass, `mem_en` stays low for exactly the number of cycles held on `settle_cycles` when `start` was accepted. A value of zero inserts no gap.
- R6: RAM read data is expected one cycle after the read is issued and is compared with that pass's pattern. On a mismatch, `done` and `fail` are both high after the next clock edge, `busy` falls, and the engine issues no further accesses.
- R7: Take the edge that accepts `start` as edge 0. On a run with no mismatch, `done` rises with `fail` low after edge DATA_W*(2*DEPTH+S)+1, where S is the settle count.
- R8: While `busy` is high, the `sys_*` inputs have no effect on the RAM port.
- R9: `start` is taken only while idle. Accepting it clears `done` and `fail` and raises `busy` after that edge. `done` and `fail` then hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test when idle |
| settle_cycles | input | WAIT_W | Idle cycles between write and read halves, sampled at start |
| sys_en | input | 1 | Functional RAM enable |
| sys_we | input | 1 | Functional write enable (1 = write) |
| sys_addr | input | ADDR_W | Functional address |
| sys_wdata | input | DATA_W | Functional write data |
| mem_en | output | 1 | RAM enable |
| mem_we | output | 1 | RAM write enable (1 = write) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after a read |
| busy | output | 1 | Test in progress, RAM owned by the engine |
| done | output | 1 | Last test has ended |
| fail | output | 1 | Last test ended on a miscompare |

## Verification
Most internal faults in this engine show up at the RAM port within one pass, and every one of them shows up by the end of the test. A wrong counter field or a wrong rotation puts the wrong address or data word on the bus at a fixed cycle, so the bench samples the bus at chosen cycle indices. A counter that skips or repeats a step moves the `done` edge away from the value given by the closed-form latency. A comparison fed with the wrong expected word, or sampled one cycle off, produces a spurious `fail`. Injected stuck-at faults must stop the run exactly two edges after the faulty read is issued, and the bench computes that point from the pass in which the faulty bit first carries the opposite value.

// File: rtl/mbd_pkg.sv
// Package: shared types for the disturb self-test engine.
// Assumes nothing beyond a standard SystemVerilog compile.
package mbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_SETTLE = 2'd2,
        ST_DRAIN  = 2'd3
    } mbd_state_e;

endpackage

// File: rtl/mbd_pattern.sv
// Module: mbd_pattern
// Builds the pass pattern: a single cleared bit that starts at the MSB and,
// for each later pass, sits one place higher after a left rotation
// (pass p >= 1 clears bit p-1). Purely combinational.
// Assumes DATA_W >= 2 and pass_idx < DATA_W. clk/rst_n only clock the checks.
module mbd_pattern #(
    parameter int DATA_W = 8,
    parameter int PASS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PASS_W-1:0] pass_idx,
    output logic [DATA_W-1:0] pattern
);

    logic [PASS_W-1:0] zero_pos;

    // Position of the single cleared bit for the current pass.
    always_comb begin
        if (pass_idx == '0) zero_pos = PASS_W'(DATA_W - 1);
        else                zero_pos = pass_idx - 1'b1;
    end

    // One comparator per data bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign pattern[i] = (zero_pos != PASS_W'(i));
    end

    // R3: exactly one bit of the pattern is cleared.
    a_r3_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pattern) == 1);

    // R4: stepping the pass by one rotates the previous pattern left by one.
    a_r4_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_idx == $past(pass_idx) + 1'b1) |->
        (pattern == {$past(pattern[DATA_W-2:0]), $past(pattern[DATA_W-1])}));

endmodule

// File: rtl/mbd_compare.sv
// Module: mbd_compare
// Registers the expected word alongside each issued read and flags a
// mismatch in the following cycle, when the RAM returns the data.
// Assumes a RAM with exactly one cycle of read latency.
module mbd_compare #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] expected,
    input  logic [DATA_W-1:0] rdata,
    output logic              mismatch
);

    logic              valid_q;
    logic [DATA_W-1:0] exp_q;

    // Track which cycle carries returned read data and what it should hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            exp_q   <= '0;
        end else begin
            valid_q <= rd_issue;
            exp_q   <= expected;
        end
    end

    // Miscompare on returned data only.
    assign mismatch = valid_q && (rdata != exp_q);

endmodule

// File: rtl/mbd_sequencer.sv
// Module: mbd_sequencer
// Owns the test state and the step counter {pass, phase, address}. The
// phase bit selects write (0) or read (1). It inserts the settle gap after
// each write half and stops on the first mismatch.
// Assumes DEPTH = 2**ADDR_W and that DATA_W passes fit in PASS_W bits.
module mbd_sequencer
    import mbd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 8,
    parameter int PASS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] settle_cycles,
    input  logic              mismatch,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              test_en,
    output logic              test_we,
    output logic [ADDR_W-1:0] test_addr,
    output logic [PASS_W-1:0] pass_idx
);

    localparam int CNT_W = PASS_W + 1 + ADDR_W;

    mbd_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [WAIT_W-1:0] settle_q;
    logic [WAIT_W-1:0] wait_cnt;
    logic              phase;
    logic              addr_last;
    logic              pass_last;

    assign test_addr = cnt[ADDR_W-1:0];
    assign phase     = cnt[ADDR_W];
    assign pass_idx  = cnt[CNT_W-1:ADDR_W+1];
    assign addr_last = &test_addr;
    assign pass_last = (pass_idx == PASS_W'(DATA_W - 1));

    // State, step counter, settle timer and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            settle_q <= '0;
            wait_cnt <= '0;
            done     <= 1'b0;
            fail     <= 1'b0;
        end else if (state != ST_IDLE && mismatch) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            fail  <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        cnt      <= '0;
                        settle_q <= settle_cycles;
                        done     <= 1'b0;
                        fail     <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (!phase && addr_last && settle_q != '0) begin
                        cnt      <= cnt + CNT_W'(1);
                        wait_cnt <= settle_q;
                        state    <= ST_SETTLE;
                    end else if (phase && addr_last && pass_last) begin
                        state <= ST_DRAIN;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (wait_cnt <= WAIT_W'(1)) state <= ST_RUN;
                    else                        wait_cnt <= wait_cnt - 1'b1;
                end
                default: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign test_en = (state == ST_RUN);
    assign test_we = !phase;

    // R2: the read half of a pass starts only after the last address was written.
    a_r2_read_after_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase) |-> ($past(test_addr) == '1));

endmodule

// File: rtl/mbd_disturb_bist.sv
// Module: mbd_disturb_bist (top)
// Disturb self-test engine: rotating single-zero pattern, write-all then
// read-all per pass, optional settle gap, halt on first miscompare. Routes
// the functional RAM request through when idle.
// Assumes a single-port synchronous RAM with one-cycle read latency,
// DEPTH = 2**ADDR_W, and DATA_W >= 2.
module mbd_disturb_bist #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] settle_cycles,
    input  logic              sys_en,
    input  logic              sys_we,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic [DATA_W-1:0] sys_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    localparam int PASS_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    logic              test_en;
    logic              test_we;
    logic [ADDR_W-1:0] test_addr;
    logic [PASS_W-1:0] pass_idx;
    logic [DATA_W-1:0] pattern;
    logic              mismatch;

    mbd_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .PASS_W(PASS_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .mismatch(mismatch), .busy(busy), .done(done), .fail(fail),
        .test_en(test_en), .test_we(test_we), .test_addr(test_addr),
        .pass_idx(pass_idx)
    );

    mbd_pattern #(.DATA_W(DATA_W), .PASS_W(PASS_W)) u_pat (
        .clk(clk), .rst_n(rst_n), .pass_idx(pass_idx), .pattern(pattern)
    );

    mbd_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .rd_issue(test_en && !test_we),
        .expected(pattern), .rdata(mem_rdata), .mismatch(mismatch)
    );

    // RAM port ownership: the engine while busy, the functional side otherwise.
    always_comb begin
        if (busy) begin
            mem_en    = test_en;
            mem_we    = test_en && test_we;
            mem_addr  = test_addr;
            mem_wdata = pattern;
        end else begin
            mem_en    = sys_en;
            mem_we    = sys_we;
            mem_addr  = sys_addr;
            mem_wdata = sys_wdata;
        end
    end

    // R6: a miscompare during a test ends it with both flags up.
    a_r6_halt_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mismatch) |=> (!busy && done && fail));

    // R7: the done flag is only ever seen while idle.
    a_r7_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: an accepted start clears the result and begins the test.
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && !fail));

endmodule

// File: tb/tb_mbd_disturb_bist.sv
module tb_mbd_disturb_bist;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int WW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [WW-1:0] settle_cycles = '0;
    logic          sys_en = 1'b0, sys_we = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [DW-1:0] sys_wdata = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, fail;

    int checks = 0;
    int errors = 0;

    // Fault injection into the RAM model (applied on the read path).
    logic          f_on = 1'b0, f_sa1 = 1'b0;
    logic [AW-1:0] f_addr = '0;
    logic [2:0]    f_bit = '0;
    logic [DW-1:0] ram [DEPTH];

    always #2 clk = ~clk;

    mbd_disturb_bist #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .sys_en(sys_en), .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail)
    );

    // Synchronous single-port RAM, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else if (f_on && mem_addr == f_addr)
                mem_rdata <= f_sa1 ? (ram[mem_addr] | (8'd1 << f_bit))
                                   : (ram[mem_addr] & ~(8'd1 << f_bit));
            else mem_rdata <= ram[mem_addr];
        end
    end

    typedef struct packed {
        logic [7:0] settle;
        logic       on;
        logic       sa1;
        logic [3:0] addr;
        logic [2:0] bitn;
        logic       exp_fail;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd0, 1'b0, 1'b0, 4'd0,  3'd0, 1'b0},
        '{8'd3, 1'b0, 1'b0, 4'd0,  3'd0, 1'b0},
        '{8'd0, 1'b1, 1'b1, 4'd5,  3'd2, 1'b1},
        '{8'd2, 1'b1, 1'b0, 4'd0,  3'd0, 1'b1},
        '{8'd0, 1'b1, 1'b1, 4'd15, 3'd7, 1'b1},
        '{8'd0, 1'b1, 1'b0, 4'd15, 3'd7, 1'b1},
        '{8'd1, 1'b1, 1'b1, 4'd9,  3'd6, 1'b1}
    };

    // Edges after the start edge until done: derived from R2, R4, R5, R6, R7.
    function automatic int exp_lat(int s, bit on, bit sa1, int a, int b);
        int per;
        int p;
        per = 2 * DEPTH + s;
        if (!on) return DW * per + 1;
        if (sa1) p = (b == DW - 1) ? 0 : b + 1;   // first pass with bit b = 0
        else     p = (b == DW - 1) ? 1 : 0;       // first pass with bit b = 1
        return p * per + DEPTH + s + a + 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Pulse start; on return the start edge has passed (edge 0).
    task automatic kick(input int s);
        settle_cycles = WW'(s);
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int lat);
        while (!done && lat < 5000) begin
            step(1);
            lat++;
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4ns * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int lat;
        step(3);
        rst_n = 1'b1;
        sys_en = 1'b1; sys_we = 1'b1; sys_addr = 4'd3; sys_wdata = 8'h5A;
        step(1);
        // R1: reset state and pass-through.
        chk(!busy && !done && !fail, "R1", "flags after reset", {busy, done, fail}, 0);
        chk(mem_en && mem_we && mem_addr == 4'd3 && mem_wdata == 8'h5A, "R1",
            "pass-through", mem_addr, 3);

        // Vector table: latency and result per run (R6, R7).
        for (int i = 0; i < 7; i++) begin
            sys_en = 1'b0; sys_we = 1'b0;
            f_on = VECS[i].on; f_sa1 = VECS[i].sa1;
            f_addr = VECS[i].addr; f_bit = VECS[i].bitn;
            kick(int'(VECS[i].settle));
            lat = 0;
            wait_done(lat);
            chk(done, "R7", "done reached", done, 1);
            chk(lat == exp_lat(int'(VECS[i].settle), VECS[i].on, VECS[i].sa1,
                               int'(VECS[i].addr), int'(VECS[i].bitn)),
                VECS[i].on ? "R6" : "R7", "latency", lat,
                exp_lat(int'(VECS[i].settle), VECS[i].on, VECS[i].sa1,
                        int'(VECS[i].addr), int'(VECS[i].bitn)));
            chk(fail == VECS[i].exp_fail, VECS[i].on ? "R6" : "R7", "fail flag",
                fail, VECS[i].exp_fail);
        end

        // Directed: bus contents, patterns, sys ignored while busy.
        f_on = 1'b0;
        sys_en = 1'b1; sys_we = 1'b1; sys_addr = 4'd9; sys_wdata = 8'hAA;
        kick(0);
        chk(!done && !fail && busy, "R9", "start clears", {busy, done, fail}, 3'b100);
        chk(mem_en && mem_we && mem_addr == 4'd0 && mem_wdata == 8'h7F, "R3",
            "pass0 first write", mem_wdata, 8'h7F);
        step(5);
        chk(mem_we && mem_addr == 4'd5, "R2", "write addr 5", mem_addr, 5);
        step(11);
        chk(mem_en && !mem_we && mem_addr == 4'd0, "R8", "read ignores sys", mem_addr, 0);
        step(15);
        chk(!mem_we && mem_addr == 4'd15, "R2", "last read addr", mem_addr, 15);
        step(1);
        chk(mem_we && mem_addr == 4'd0 && mem_wdata == 8'hFE, "R4", "pass1 pattern",
            mem_wdata, 8'hFE);
        step(32);
        chk(mem_we && mem_wdata == 8'hFD, "R4", "pass2 pattern", mem_wdata, 8'hFD);
        lat = 64;
        wait_done(lat);
        chk(done && !fail && lat == exp_lat(0, 0, 0, 0, 0), "R8",
            "run clean despite sys writes", lat, exp_lat(0, 0, 0, 0, 0));
        sys_en = 1'b0; sys_we = 1'b0;

        // Directed: settle gap of three cycles.
        kick(3);
        step(15);
        chk(mem_en && mem_we && mem_addr == 4'd15, "R5", "last write", mem_addr, 15);
        step(1);
        chk(!mem_en, "R5", "gap cycle 1", mem_en, 0);
        step(2);
        chk(!mem_en, "R5", "gap cycle 3", mem_en, 0);
        step(1);
        chk(mem_en && !mem_we && mem_addr == 4'd0, "R5", "first read after gap",
            {mem_en, mem_we}, 2'b10);
        lat = 19;
        wait_done(lat);
        chk(!fail, "R5", "settled run clean", fail, 0);

        // Directed: early stop, then results hold, then restart clears.
        f_on = 1'b1; f_sa1 = 1'b1; f_addr = 4'd2; f_bit = 3'd7;
        kick(0);
        step(19);
        chk(busy && !done, "R6", "still running before stop", busy, 1);
        step(1);
        chk(done && fail && !busy && !mem_en, "R6", "halt and release",
            {done, fail, busy, mem_en}, 4'b1100);
        step(6);
        chk(done && fail && !mem_en, "R9", "result holds", {done, fail}, 2'b11);
        f_on = 1'b0;
        kick(0);
        chk(busy && !done && !fail, "R9", "restart clears", {busy, done, fail}, 3'b100);
        lat = 0;
        wait_done(lat);
        chk(done && !fail, "R7", "clean after restart", fail, 0);

        summary();
    end

endmodule